// File: doc/BRIEF.md
# In-Order Retirement Queue with Fault Flush

This block is a circular result queue that sits between instruction dispatch and the register file of an out-of-order core. Dispatch claims one slot per instruction in program order and receives a slot tag. Execution units may finish in any order; each one reports its result through a completion port addressed by that tag, with a flag that marks the result as faulting (an exception or a mispredicted branch).

Results leave the queue only from the oldest slot and one per cycle. A finished younger result waits until every older one has retired. When the oldest slot holds a flagged result, the queue raises a one-cycle flush, reports the tag of that slot as the restart point, and drops that slot and every younger one without writing any of them. Allocation then resumes at the restart tag.

Top module: `rob_core`

## Requirements
- R1: Granted allocations return consecutive slot tags, wrapping from DEPTH-1 to 0; after a flush the first granted tag equals the reported restart tag.
- R2: alloc_gnt_o is high exactly when alloc_req_i is high, the queue is not full and no flush is being raised; full_o is high when DEPTH slots are held, empty_o when none are.
- R3: retire_vld_o is high in a cycle exactly when the oldest held slot has completed without a fault flag; it then carries that slot's tag, destination and data, and the slot is released at the clock edge.
- R4: A completed slot never retires while any older slot has not completed; up to DEPTH-1 younger results may wait behind one unfinished oldest slot.
- R5: Completions accepted in any order retire in allocation order, each with the data given at its completion.
- R6: When the oldest held slot completed with the fault flag set, flush_o is high for one cycle with restart_tag_o equal to that slot's tag, retire_vld_o stays low, and the queue is empty in the next cycle.
- R7: A completion whose tag names a slot that is not waiting for a result (free, or already completed) changes nothing: a slot allocated afterwards under that tag still waits for its own completion.
- R8: After reset the queue is empty, not full, and raises neither retire_vld_o nor flush_o.
- R9: Slots younger than a flagged slot are discarded by the flush and never retire, even if they completed earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alloc_req_i | input | 1 | Dispatch asks for a slot |
| alloc_dest_i | input | DEST_W | Destination register of the dispatched instruction |
| alloc_gnt_o | output | 1 | Slot granted this cycle |
| alloc_tag_o | output | $clog2(DEPTH) | Tag of the slot granted |
| done_vld_i | input | 1 | Completion write valid |
| done_tag_i | input | $clog2(DEPTH) | Tag of the completing slot |
| done_data_i | input | DATA_W | Result data |
| done_fault_i | input | 1 | Result is an exception or mispredict |
| retire_vld_o | output | 1 | Register file write this cycle |
| retire_tag_o | output | $clog2(DEPTH) | Tag of the oldest slot |
| retire_dest_o | output | DEST_W | Destination register to write |
| retire_data_o | output | DATA_W | Data to write |
| flush_o | output | 1 | Discard oldest slot and all younger |
| restart_tag_o | output | $clog2(DEPTH) | Tag of the flagged slot during a flush |
| full_o | output | 1 | All slots held |
| empty_o | output | 1 | No slot held |

## Verification
The bench builds the queue with DEPTH=4, DATA_W=8 and DEST_W=3, small enough that every one of the 24 completion orders of a full queue is swept, with the oldest slot blocking retirement in the orders that finish it last. With four slots the fault position can also be placed at each slot in turn, behind earlier retirements and ahead of already finished younger slots, and both wrap bit values of the pointers are crossed many times.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE  = 2'd0,
    SLOT_BUSY  = 2'd1,
    SLOT_DONE  = 2'd2,
    SLOT_FAULT = 2'd3
  } slot_e;
endpackage

// File: rtl/rob_ptr.sv
module rob_ptr #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             rewind_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] head_q, tail_q;
  logic             head_wrap_q, tail_wrap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q      <= '0;
      head_wrap_q <= 1'b0;
    end else if (pop_i) begin
      head_q      <= (head_q == LAST) ? '0 : head_q + 1'b1;
      head_wrap_q <= head_wrap_q ^ (head_q == LAST);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tail_q      <= '0;
      tail_wrap_q <= 1'b0;
    end else if (rewind_i) begin
      tail_q      <= head_q;
      tail_wrap_q <= head_wrap_q;
    end else if (push_i) begin
      tail_q      <= (tail_q == LAST) ? '0 : tail_q + 1'b1;
      tail_wrap_q <= tail_wrap_q ^ (tail_q == LAST);
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign full_o  = (head_q == tail_q) && (head_wrap_q != tail_wrap_q);
  assign empty_o = (head_q == tail_q) && (head_wrap_q == tail_wrap_q);
endmodule

// File: rtl/rob_slot.sv
module rob_slot
  import rob_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEST_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [DEST_W-1:0] dest_i,
  input  logic              done_i,
  input  logic              fault_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              release_i,
  input  logic              clear_i,
  output slot_e             state_o,
  output logic [DEST_W-1:0] dest_o,
  output logic [DATA_W-1:0] data_o
);
  slot_e             state_q;
  logic [DEST_W-1:0] dest_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SLOT_FREE;
      dest_q  <= '0;
      data_q  <= '0;
    end else if (clear_i || release_i) begin
      state_q <= SLOT_FREE;
    end else if (alloc_i) begin
      state_q <= SLOT_BUSY;
      dest_q  <= dest_i;
    end else if (done_i && state_q == SLOT_BUSY) begin
      // only a slot waiting for its result accepts one
      state_q <= fault_i ? SLOT_FAULT : SLOT_DONE;
      data_q  <= data_i;
    end
  end

  assign state_o = state_q;
  assign dest_o  = dest_q;
  assign data_o  = data_q;
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEST_W = 5,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_req_i,
  input  logic [DEST_W-1:0] alloc_dest_i,
  output logic              alloc_gnt_o,
  output logic [PTR_W-1:0]  alloc_tag_o,
  input  logic              done_vld_i,
  input  logic [PTR_W-1:0]  done_tag_i,
  input  logic [DATA_W-1:0] done_data_i,
  input  logic              done_fault_i,
  output logic              retire_vld_o,
  output logic [PTR_W-1:0]  retire_tag_o,
  output logic [DEST_W-1:0] retire_dest_o,
  output logic [DATA_W-1:0] retire_data_o,
  output logic              flush_o,
  output logic [PTR_W-1:0]  restart_tag_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [PTR_W-1:0]  head, tail;
  logic              full, empty, pop, flush, push;
  slot_e             slot_state [DEPTH];
  logic [DEST_W-1:0] slot_dest  [DEPTH];
  logic [DATA_W-1:0] slot_data  [DEPTH];

  assign pop   = (slot_state[head] == SLOT_DONE);
  assign flush = (slot_state[head] == SLOT_FAULT);
  assign push  = alloc_req_i && !full && !flush;

  rob_ptr #(.DEPTH(DEPTH)) i_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (push),
    .pop_i    (pop),
    .rewind_i (flush),
    .head_o   (head),
    .tail_o   (tail),
    .full_o   (full),
    .empty_o  (empty)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    rob_slot #(.DATA_W(DATA_W), .DEST_W(DEST_W)) i_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .alloc_i   (push && tail == PTR_W'(g)),
      .dest_i    (alloc_dest_i),
      .done_i    (done_vld_i && done_tag_i == PTR_W'(g)),
      .fault_i   (done_fault_i),
      .data_i    (done_data_i),
      .release_i (pop && head == PTR_W'(g)),
      .clear_i   (flush),
      .state_o   (slot_state[g]),
      .dest_o    (slot_dest[g]),
      .data_o    (slot_data[g])
    );
  end

  assign alloc_gnt_o   = push;
  assign alloc_tag_o   = tail;
  assign retire_vld_o  = pop;
  assign retire_tag_o  = head;
  assign retire_dest_o = slot_dest[head];
  assign retire_data_o = slot_data[head];
  assign flush_o       = flush;
  assign restart_tag_o = head;
  assign full_o        = full;
  assign empty_o       = empty;
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             alloc_req_i,
  input logic             alloc_gnt_o,
  input logic [PTR_W-1:0] alloc_tag_o,
  input logic             retire_vld_o,
  input logic [PTR_W-1:0] retire_tag_o,
  input logic             flush_o,
  input logic [PTR_W-1:0] restart_tag_o,
  input logic             full_o,
  input logic             empty_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  AST_NO_GNT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !alloc_gnt_o); // R2
  AST_GNT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_gnt_o |-> alloc_req_i); // R2
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o)); // R2
  AST_TAG_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_gnt_o |=> alloc_tag_o == (($past(alloc_tag_o) == LAST) ? '0 : $past(alloc_tag_o) + 1'b1)); // R1
  AST_EMPTY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !retire_vld_o && !flush_o); // R3
  AST_HEAD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_vld_o |=> retire_tag_o == (($past(retire_tag_o) == LAST) ? '0 : $past(retire_tag_o) + 1'b1)); // R5
  AST_FLUSH_NO_RETIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> !retire_vld_o); // R6
  AST_FLUSH_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o && empty_o); // R6
  AST_RESTART_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> alloc_tag_o == $past(restart_tag_o)); // R1
endmodule

bind rob_core rob_checker #(.DEPTH(DEPTH)) i_rob_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .alloc_req_i   (alloc_req_i),
  .alloc_gnt_o   (alloc_gnt_o),
  .alloc_tag_o   (alloc_tag_o),
  .retire_vld_o  (retire_vld_o),
  .retire_tag_o  (retire_tag_o),
  .flush_o       (flush_o),
  .restart_tag_o (restart_tag_o),
  .full_o        (full_o),
  .empty_o       (empty_o)
);

// File: tb/test_rob_core.sv
`timescale 1ns/1ps
module test_rob_core;
  localparam int DEPTH = 4;
  localparam int DATA_W = 8;
  localparam int DEST_W = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic alloc_req_i = 1'b0;
  logic [DEST_W-1:0] alloc_dest_i = '0;
  logic alloc_gnt_o;
  logic [1:0] alloc_tag_o;
  logic done_vld_i = 1'b0;
  logic [1:0] done_tag_i = '0;
  logic [DATA_W-1:0] done_data_i = '0;
  logic done_fault_i = 1'b0;
  logic retire_vld_o;
  logic [1:0] retire_tag_o;
  logic [DEST_W-1:0] retire_dest_o;
  logic [DATA_W-1:0] retire_data_o;
  logic flush_o;
  logic [1:0] restart_tag_o;
  logic full_o, empty_o;

  always #2 clk_i = ~clk_i;

  rob_core #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W)) i_rob_core (.*);

  int n_chk = 0, n_fail = 0, n_cyc = 0;
  // reference state: 0 free, 1 waiting, 2 done, 3 faulted
  int ms[DEPTH], md[DEPTH], mdst[DEPTH];
  int mh = 0, mt = 0, mc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // called just after a falling edge: check outputs, drive inputs, advance the model
  task automatic cyc(input string quiet_req, input bit al, input int dst,
                     input bit cv, input int ct, input int cd, input bit cf);
    bit ec, ef, eg;
    ec = (ms[mh] == 2);
    ef = (ms[mh] == 3);
    chk(retire_vld_o == ec, ec ? "R3" : quiet_req, int'(retire_vld_o), int'(ec));
    chk(flush_o == ef, "R6", int'(flush_o), int'(ef));
    chk(full_o == (mc == DEPTH), "R2", int'(full_o), int'(mc == DEPTH));
    chk(empty_o == (mc == 0), "R2", int'(empty_o), int'(mc == 0));
    if (ec) begin
      chk(retire_tag_o == 2'(mh), "R3", int'(retire_tag_o), mh);
      chk(retire_dest_o == 3'(mdst[mh]), "R3", int'(retire_dest_o), mdst[mh]);
      chk(retire_data_o == 8'(md[mh]), "R5", int'(retire_data_o), md[mh]);
    end
    if (ef) chk(restart_tag_o == 2'(mh), "R6", int'(restart_tag_o), mh);
    alloc_req_i  = al;
    alloc_dest_i = 3'(dst);
    done_vld_i   = cv;
    done_tag_i   = 2'(ct);
    done_data_i  = 8'(cd);
    done_fault_i = cf;
    #1;
    eg = al && (mc != DEPTH) && !ef;
    chk(alloc_gnt_o == eg, "R2", int'(alloc_gnt_o), int'(eg));
    if (eg) chk(alloc_tag_o == 2'(mt), "R1", int'(alloc_tag_o), mt);
    if (cv && !ef && ms[ct] == 1) begin
      ms[ct] = cf ? 3 : 2;
      md[ct] = cd & 8'hFF;
    end
    if (ec) begin ms[mh] = 0; mh = (mh + 1) % DEPTH; mc--; end
    if (ef) begin
      for (int i = 0; i < DEPTH; i++) ms[i] = 0;
      mt = mh; mc = 0;
    end
    if (eg) begin ms[mt] = 1; mdst[mt] = dst & 7; mt = (mt + 1) % DEPTH; mc++; end
    @(negedge clk_i);
  endtask

  task automatic idle(input string req, input int n);
    for (int i = 0; i < n; i++) cyc(req, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk_i) begin
    n_cyc++;
    if (n_cyc > 50000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", n_cyc, 50000);
      finish_run();
    end
  end

  initial begin
    int base, pid, ord[4];
    for (int i = 0; i < DEPTH; i++) begin ms[i] = 0; md[i] = 0; mdst[i] = 0; end
    #1;
    // R8: reset state
    chk(empty_o == 1'b1, "R8", int'(empty_o), 1);
    chk(full_o == 1'b0, "R8", int'(full_o), 0);
    chk(retire_vld_o == 1'b0, "R8", int'(retire_vld_o), 0);
    chk(flush_o == 1'b0, "R8", int'(flush_o), 0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R4/R5: every completion order of a full queue
    pid = 0;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++) begin
            if (a == b || a == c || a == d || b == c || b == d || c == d) continue;
            ord[0] = a; ord[1] = b; ord[2] = c; ord[3] = d;
            base = mt;
            for (int k = 0; k < 4; k++) cyc("R4", 1, (k + pid) % 8, 0, 0, 0, 0);
            cyc("R4", 1, 7, 0, 0, 0, 0);   // R2: blocked while full
            for (int k = 0; k < 4; k++)
              cyc("R4", 0, 0, 1, (base + ord[k]) % 4, pid * 4 + ord[k], 0);
            idle("R4", 5);
            pid++;
          end

    // R6/R9: fault at each position, younger slots already finished
    for (int f = 0; f < 4; f++) begin
      base = mt;
      for (int k = 0; k < 4; k++) cyc("R9", 1, k, 0, 0, 0, 0);
      for (int k = 3; k >= 0; k--)
        cyc("R9", 0, 0, 1, (base + k) % 4, 100 + f * 4 + k, k == f);
      idle("R9", 6);
      // R7: completion to a discarded tag
      cyc("R7", 0, 0, 1, (base + 3) % 4, 77, 0);
      idle("R7", 2);
      // R1: first tag after a flush is the restart tag
      base = mt;
      chk(alloc_tag_o == 2'((base)), "R1", int'(alloc_tag_o), base);
      cyc("R7", 1, 5, 0, 0, 0, 0);
      cyc("R7", 0, 0, 1, base, 200 + f, 0);
      idle("R7", 2);
    end

    // R7: stale completion before allocation does not mark the slot done
    base = mt;
    cyc("R7", 0, 0, 1, base, 33, 0);
    cyc("R7", 1, 2, 1, base, 44, 1);
    idle("R7", 3);
    cyc("R7", 0, 0, 1, base, 55, 0);
    idle("R7", 2);

    // R3: back-to-back allocate and complete, one retirement per cycle
    for (int k = 0; k < 8; k++)
      cyc("R3", 1, k, k > 0, (mt + 3) % 4, 150 + k, 0);
    idle("R3", 6);

    finish_run();
  end
endmodule